// File: doc/BRIEF.md
# Multi-Mode Serial Port

A full-duplex serial port with one synchronous shift mode and three asynchronous framed modes, selected by a two-bit mode input. In the shift mode the port drives its own shift clock at one twelfth of the system clock. Eight bits go out on the transmit line, and eight bits are taken in from the receive line on the same clock. The asynchronous modes send and receive start/data/stop frames. The bit timing comes from a sixteen-times oversample tick. That tick is either a fixed prescale of the system clock or one pulse per overflow of an external counter.

The receiver resolves each bit by a two-of-three vote taken around the middle of the bit. It drops a start edge that does not hold low up to that point. Finished bytes are moved into a holding register, so the shifter is free for the next frame while software reads the previous one. The ninth received bit is stored next to the byte. A filter input lets only frames whose ninth bit (or stop bit, in the ten-bit mode) is 1 raise the receive interrupt, which supports address-based wake-up on a shared line. The transmitter has a single buffer. A write that arrives while a frame is in flight is discarded.

Top module: `sio_port`

## Requirements
- R1: After reset, txd and sclk are 1, and tx_irq and rx_irq are 0.
- R2: With mode = 1, a frame is 10 bit times long: a 0 start bit, 8 data bits with the LSB first, and a 1 stop bit. One bit time is 16 pulses of ovf_pulse. This holds for both the transmitter and the receiver.
- R3: With mode = 2 or mode = 3, a frame is 11 bit times: a 0 start bit, 8 data bits with the LSB first, a ninth bit, and a 1 stop bit. The transmitter sends tx_bit9 as the ninth bit. A bit time is 64 clk cycles in mode 2 and 16 ovf_pulse pulses in mode 3.
- R4: With mode = 0, a write shifts 8 bits out on txd, LSB first. sclk is low for 6 clk cycles and then high for 6 clk cycles for each bit. rxd is sampled on each rising sclk. When rx_en is 1, the 8 sampled bits (first sample in the LSB) are delivered as a received byte with rx_bit9 = 0. tx_irq is set at the end of the transfer.
- R5: Each received asynchronous bit is the majority of three samples taken at oversample counts 7, 8 and 9 of the bit. A disturbance that covers only one of the samples does not change the received value.
- R6: A start edge whose vote at the start bit's centre is 1 is dropped. No byte is delivered, and the receiver waits for the next falling edge.
- R7: A completed frame moves into the holding register only when rx_irq is 0. A frame may therefore arrive while the previous byte is still unread. If rx_irq is still 1 when the next frame completes, the held byte and ninth bit stay unchanged and the new frame is lost.
- R8: With mode = 2 or mode = 3 and addr_filt = 1, a frame is delivered only when its ninth bit is 1.
- R9: With mode = 1 and addr_filt = 1, a frame is delivered only when its stop bit is 1. The stop bit is reported on rx_bit9 in mode 1.
- R10: A tx_wr pulse while a transfer is in progress is ignored. The frame in flight is unchanged, and no second frame follows it.
- R11: While rx_en = 0, no frame is delivered and rx_irq stays 0.
- R12: tx_irq is set when the last bit of a transfer finishes and is cleared by an accepted tx_wr. rx_irq is set on delivery and cleared by rx_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | 0 shift, 1 ten-bit frame, 2 eleven-bit at fixed rate, 3 eleven-bit at counter rate |
| rx_en | input | 1 | Receive enable |
| addr_filt | input | 1 | Deliver only frames whose ninth (mode 1: stop) bit is 1 |
| tx_bit9 | input | 1 | Ninth bit sent in modes 2 and 3 |
| ovf_pulse | input | 1 | One-cycle pulse per external counter overflow |
| tx_wr | input | 1 | Start a transfer of tx_data |
| tx_data | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Acknowledge the held byte, clears rx_irq |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, 1 when idle |
| sclk | output | 1 | Shift clock in mode 0, 1 otherwise |
| rx_data | output | 8 | Held received byte |
| rx_bit9 | output | 1 | Held ninth bit (stop bit in mode 1, 0 in mode 0) |
| tx_irq | output | 1 | Transmit done flag |
| rx_irq | output | 1 | Receive data ready flag |

## Verification
If the oversample phase or bit index drifts, the error shows at txd within one bit time as a shifted or stretched bit. On the receive side it shows when the next frame is delivered, as a wrong byte or a missing rx_irq. If the vote or start-rejection logic is wrong, a glitched bit or a short low pulse produces a corrupted or phantom byte that the scoreboard catches at the next rx_irq. If the holding register or the filter is wrong, data is overwritten while rx_irq is high, or a flag rises for a filtered frame; either shows within one frame.

// File: rtl/sio_port.sv
`timescale 1ns/1ps
module sio_port #(
  parameter int M0_DIV = 12,
  parameter int M2_DIV = 64,
  parameter int OS     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       rx_en,
  input  logic       addr_filt,
  input  logic       tx_bit9,
  input  logic       ovf_pulse,
  input  logic       tx_wr,
  input  logic [7:0] tx_data,
  input  logic       rx_rd,
  input  logic       rxd,
  output logic       txd,
  output logic       sclk,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       tx_irq,
  output logic       rx_irq
);
  localparam int PRE  = M2_DIV / OS;
  localparam int PW   = $clog2(PRE + 1);
  localparam int OW   = $clog2(OS);
  localparam int CW   = $clog2(M0_DIV);
  localparam int HALF = M0_DIV / 2;
  localparam int VA   = OS / 2 - 1;

  wire m0 = mode == 2'd0;
  wire m1 = mode == 2'd1;
  wire m2 = mode == 2'd2;

  logic [1:0] rx_sync;
  wire rxs = rx_sync[1];
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_sync <= 2'b11;
    else        rx_sync <= {rx_sync[0], rxd};

  logic [PW-1:0] pre;
  wire pre_end = pre == PW'(PRE - 1);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       pre <= '0;
    else if (pre_end) pre <= '0;
    else              pre <= pre + PW'(1);

  wire tick = m2 ? pre_end : ovf_pulse;

  // transmitter
  logic          tx_busy;
  logic [10:0]   tx_sh;
  logic [3:0]    tx_left;
  logic [OW-1:0] tx_ph;
  logic [CW-1:0] m0_cnt;

  wire m0_end  = m0_cnt == CW'(M0_DIV - 1);
  wire tph_end = tx_ph == OW'(OS - 1);
  wire tx_step = tx_busy && (m0 ? m0_end : (tick && tph_end));
  wire tx_fin  = tx_step && tx_left == 4'd1;
  wire tx_go   = tx_wr && !tx_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_left <= '0;
      tx_ph   <= '0;
      m0_cnt  <= '0;
      tx_irq  <= 1'b0;
    end else if (tx_go) begin
      tx_busy <= 1'b1;
      tx_irq  <= 1'b0;
      tx_ph   <= '0;
      m0_cnt  <= '0;
      case (mode)
        2'd0:    begin tx_sh <= {3'b111, tx_data};             tx_left <= 4'd8;  end
        2'd1:    begin tx_sh <= {2'b11, tx_data, 1'b0};        tx_left <= 4'd10; end
        default: begin tx_sh <= {1'b1, tx_bit9, tx_data, 1'b0}; tx_left <= 4'd11; end
      endcase
    end else if (tx_busy) begin
      m0_cnt <= m0_end ? '0 : m0_cnt + CW'(1);
      if (tick) tx_ph <= tph_end ? '0 : tx_ph + OW'(1);
      if (tx_step) begin
        tx_sh   <= {1'b1, tx_sh[10:1]};
        tx_left <= tx_left - 4'd1;
      end
      if (tx_fin) begin
        tx_busy <= 1'b0;
        tx_irq  <= 1'b1;
      end
    end
  end

  assign txd  = tx_busy ? tx_sh[0] : 1'b1;
  assign sclk = !(tx_busy && m0 && m0_cnt < CW'(HALF));

  // shift-mode capture
  logic [7:0] m0_rx;
  wire m0_smp = tx_busy && m0 && m0_cnt == CW'(HALF);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      m0_rx <= '0;
    else if (m0_smp) m0_rx <= {rxs, m0_rx[7:1]};

  // asynchronous receiver
  logic          rx_act, rx_last, va, vb;
  logic [OW-1:0] rx_ph;
  logic [3:0]    rx_idx;
  logic [9:0]    rx_sh;

  wire       vote    = (va & vb) | (va & rxs) | (vb & rxs);
  wire       at_vote = rx_act && tick && rx_ph == OW'(VA + 2);
  wire [9:0] rx_nx   = {vote, rx_sh[9:1]};
  wire       rx_end  = at_vote && rx_idx == (m1 ? 4'd9 : 4'd10);
  wire [7:0] a_dat   = m1 ? rx_nx[8:1] : rx_nx[7:0];
  wire       a_b9    = m1 ? rx_nx[9] : rx_nx[8];
  wire       a_ok    = !addr_filt || a_b9;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_act  <= 1'b0;
      rx_last <= 1'b1;
      rx_ph   <= '0;
      rx_idx  <= '0;
      rx_sh   <= '0;
      va      <= 1'b1;
      vb      <= 1'b1;
    end else if (tick) begin
      rx_last <= rxs;
      if (!rx_act) begin
        if (rx_en && !m0 && rx_last && !rxs) begin
          rx_act <= 1'b1;
          rx_ph  <= '0;
          rx_idx <= '0;
        end
      end else begin
        rx_ph <= (rx_ph == OW'(OS - 1)) ? '0 : rx_ph + OW'(1);
        if (rx_ph == OW'(VA))     va <= rxs;
        if (rx_ph == OW'(VA + 1)) vb <= rxs;
        if (rx_ph == OW'(OS - 1)) rx_idx <= rx_idx + 4'd1;
        if (at_vote) begin
          if (rx_idx == 4'd0) begin
            if (vote) rx_act <= 1'b0;
          end else begin
            rx_sh <= rx_nx;
          end
          if (rx_end) rx_act <= 1'b0;
        end
      end
    end
  end

  // holding register
  wire m0_wr = tx_fin && m0 && rx_en;
  wire a_wr  = rx_end && a_ok && rx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_irq  <= 1'b0;
      rx_data <= '0;
      rx_bit9 <= 1'b0;
    end else begin
      if (rx_rd) rx_irq <= 1'b0;
      if (!rx_irq && (m0_wr || a_wr)) begin
        rx_irq  <= 1'b1;
        rx_data <= m0_wr ? m0_rx : a_dat;
        rx_bit9 <= m0_wr ? 1'b0 : a_b9;
      end
    end
  end
endmodule

module sio_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       addr_filt,
  input logic       rx_en,
  input logic       rx_rd,
  input logic       tx_wr,
  input logic       tx_busy,
  input logic       rx_irq,
  input logic       rx_bit9,
  input logic       tx_irq,
  input logic       txd,
  input logic       sclk,
  input logic [7:0] rx_data
);
  // R8, R9
  filt_ninth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_irq) && mode != 2'd0 && $stable(mode) && $stable(addr_filt) && addr_filt) |-> rx_bit9);

  // R7
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && !rx_rd) |=> (rx_irq && $stable(rx_data) && $stable(rx_bit9)));

  // R11
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rx_irq) |=> !rx_irq);

  // R2
  tx_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_irq) |-> (txd && !tx_busy));

  // R12
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !tx_busy) |=> (!tx_irq && tx_busy));

  // R4
  sclk_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> mode == 2'd0);
endmodule

bind sio_port sio_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .addr_filt(addr_filt), .rx_en(rx_en),
  .rx_rd(rx_rd), .tx_wr(tx_wr), .tx_busy(tx_busy), .rx_irq(rx_irq),
  .rx_bit9(rx_bit9), .tx_irq(tx_irq), .txd(txd), .sclk(sclk), .rx_data(rx_data)
);

// File: tb/test_sio_port.sv
`timescale 1ns/1ps
module test_sio_port;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd1;
  logic       rx_en = 1'b0, addr_filt = 1'b0, tx_bit9 = 1'b0, ovf_pulse = 1'b0;
  logic       tx_wr = 1'b0, rx_rd = 1'b0, rxd = 1'b1;
  logic [7:0] tx_data = 8'h00;
  wire  [7:0] rx_data;
  wire        rx_bit9, tx_irq, rx_irq, txd, sclk;

  int errs = 0, checks = 0;
  bit hold_rd = 1'b0;
  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic [8:0] mon_e;
  string      mon_t;

  sio_port i_sio_port (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rx_en(rx_en), .addr_filt(addr_filt),
    .tx_bit9(tx_bit9), .ovf_pulse(ovf_pulse), .tx_wr(tx_wr), .tx_data(tx_data),
    .rx_rd(rx_rd), .rxd(rxd), .txd(txd), .sclk(sclk), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    ovf_pulse = ~ovf_pulse;
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (rx_irq && !hold_rd) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 spurious delivery", {rx_bit9, rx_data}, 0);
      end else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        chk({rx_bit9, rx_data} == mon_e, mon_t, {rx_bit9, rx_data}, mon_e);
      end
      repeat (40) @(negedge clk);
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
      chk(!rx_irq, "R12 rx_rd clears flag", rx_irq, 0);
    end
  end

  task automatic send(input int bt, input int nb, input logic [10:0] bits, input int gbit);
    for (int i = 0; i < nb; i++)
      for (int k = 0; k < bt; k++) begin
        rxd = (i == gbit && k >= 30 && k < 33) ? ~bits[i] : bits[i];
        @(negedge clk);
      end
    rxd = 1'b1;
  endtask

  task automatic rx_frame(input logic [7:0] d, input logic b9, input logic stp,
                          input bit ok, input string t, input int gbit, input int gap);
    int bt, nb;
    logic [10:0] bits;
    bt = (mode == 2'd2) ? 64 : 32;
    if (mode == 2'd1) begin nb = 10; bits = {1'b0, stp, d, 1'b0}; end
    else              begin nb = 11; bits = {stp, b9, d, 1'b0}; end
    if (ok) begin
      exp_q.push_back({(mode == 2'd1) ? stp : b9, d});
      tag_q.push_back(t);
    end
    send(bt, nb, bits, gbit);
    repeat (gap) @(negedge clk);
  endtask

  task automatic drain(input string t);
    int n = 0;
    while ((exp_q.size() != 0 || rx_irq) && n < 4000) begin
      @(negedge clk);
      n++;
    end
    chk(exp_q.size() == 0, t, exp_q.size(), 0);
  endtask

  task automatic tx_frame(input logic [7:0] d, input logic b9, input string t, input bit poke);
    int bt, nb, w, lows;
    logic [10:0] f, got;
    bt = (mode == 2'd2) ? 64 : 32;
    nb = (mode == 2'd1) ? 10 : 11;
    f  = (mode == 2'd1) ? {1'b0, 1'b1, d, 1'b0} : {1'b1, b9, d, 1'b0};
    got = '0;
    tx_bit9 = b9; tx_data = d; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    chk(tx_irq == 1'b0, "R12 accepted write clears tx_irq", tx_irq, 0);
    w = bt / 2 - 1;
    for (int i = 0; i < nb; i++) begin
      repeat (w) @(negedge clk);
      got[i] = txd;
      w = bt;
      if (poke && i == 3) begin
        tx_data = ~d; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        w = bt - 1;
      end
    end
    chk(got == f, t, got, f);
    repeat (bt / 2 + 8) @(negedge clk);
    chk(tx_irq == 1'b1, "R12 tx_irq after last bit", tx_irq, 1);
    lows = 0;
    repeat (2 * bt) begin
      @(negedge clk);
      if (!txd) lows++;
    end
    chk(lows == 0, poke ? "R10 busy write sent nothing" : "R2 line idle after frame", lows, 0);
  endtask

  task automatic m0_xfer(input logic [7:0] d, input logic [7:0] pat);
    longint t0;
    int bad;
    logic [7:0] got;
    bad = 0; t0 = 0; got = '0;
    mode = 2'd0;
    rxd  = pat[0];
    exp_q.push_back({1'b0, pat});
    tag_q.push_back("R4 shift-in byte");
    repeat (4) @(negedge clk);
    tx_data = d; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(posedge sclk);
      if (i > 0 && ($time - t0) != 240) bad++;
      t0 = $time;
      @(negedge clk);
      got[i] = txd;
      if (i < 7) begin
        @(negedge sclk);
        @(negedge clk);
        rxd = pat[i + 1];
      end
    end
    chk(got == d, "R4 shift-out LSB first", got, d);
    chk(bad == 0, "R4 sclk period of 12 cycles", bad, 0);
    repeat (20) @(negedge clk);
    chk(tx_irq == 1'b1, "R4 tx_irq at end of shift", tx_irq, 1);
    rxd = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(txd == 1'b1,    "R1 txd idle in reset", txd, 1);
    chk(sclk == 1'b1,   "R1 sclk idle in reset", sclk, 1);
    chk(tx_irq == 1'b0, "R1 tx_irq clear in reset", tx_irq, 0);
    chk(rx_irq == 1'b0, "R1 rx_irq clear in reset", rx_irq, 0);
    rst_n = 1'b1;
    rx_en = 1'b1;
    repeat (5) @(negedge clk);

    mode = 2'd1; tx_frame(8'hA5, 1'b0, "R2 ten-bit frame out", 1'b0);
    mode = 2'd2; tx_frame(8'h3C, 1'b1, "R3 R10 eleven-bit frame at clk/64", 1'b1);
    mode = 2'd3; tx_frame(8'h5A, 1'b0, "R3 eleven-bit frame at counter rate", 1'b0);

    m0_xfer(8'hC3, 8'h6D);
    drain("R4 shift-in delivered");

    mode = 2'd1;
    rx_frame(8'h96, 1'b0, 1'b1, 1'b1, "R2 ten-bit frame in", -1, 0);
    rx_frame(8'h01, 1'b0, 1'b1, 1'b1, "R7 back-to-back second byte", -1, 32);
    drain("R7 both back-to-back frames delivered");

    mode = 2'd2;
    rx_frame(8'hFF, 1'b1, 1'b1, 1'b1, "R5 glitched bit voted out", 3, 64);
    drain("R5 glitched frame delivered");

    rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (900) @(negedge clk);
    chk(rx_irq == 1'b0, "R6 short low pulse not delivered", rx_irq, 0);
    rx_frame(8'h42, 1'b0, 1'b1, 1'b1, "R6 frame after false start", -1, 64);
    drain("R6 receiver recovered");

    mode = 2'd3; addr_filt = 1'b1;
    rx_frame(8'h11, 1'b0, 1'b1, 1'b0, "", -1, 32);
    chk(rx_irq == 1'b0, "R8 ninth bit 0 filtered", rx_irq, 0);
    rx_frame(8'h7E, 1'b1, 1'b1, 1'b1, "R8 address frame delivered", -1, 32);
    drain("R8 filter pass");

    mode = 2'd1;
    rx_frame(8'h33, 1'b0, 1'b0, 1'b0, "", -1, 64);
    chk(rx_irq == 1'b0, "R9 bad stop bit filtered", rx_irq, 0);
    rx_frame(8'hC4, 1'b0, 1'b1, 1'b1, "R9 good stop bit delivered", -1, 32);
    drain("R9 filter pass");
    addr_filt = 1'b0;

    mode = 2'd2; hold_rd = 1'b1;
    rx_frame(8'hA1, 1'b0, 1'b1, 1'b1, "R7 held byte after overrun", -1, 0);
    rx_frame(8'hB2, 1'b1, 1'b1, 1'b0, "", -1, 64);
    chk(rx_irq == 1'b1 && rx_data == 8'hA1 && rx_bit9 == 1'b0,
        "R7 overrun keeps first byte", {rx_irq, rx_bit9, rx_data}, {1'b1, 1'b0, 8'hA1});
    hold_rd = 1'b0;
    drain("R7 held byte delivered");

    rx_en = 1'b0; mode = 2'd1;
    rx_frame(8'h5C, 1'b0, 1'b1, 1'b0, "", -1, 64);
    chk(rx_irq == 1'b0, "R11 receive disabled", rx_irq, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule